// File: doc/BRIEF.md
# Sequential Complex Multiplier on One Multiply-Accumulate Unit

This block forms the product of two complex numbers, X = Xr + j·Xi and Y = Yr + j·Yi, with a single signed multiplier and a single accumulator. Each operand pair is stored locally in two slots, one for the real and one for the imaginary component. Each component is therefore taken from the source once per product, over one input handshake.

A small sequencer then steps through four multiply cycles. On each clock it picks which stored slot feeds each side of the multiplier. It also picks whether the accumulator is loaded with the product, reduced by it, or increased by it.

The real part Xr·Yr − Xi·Yi appears first on a shared result bus, marked by its own strobe. Two cycles later the imaginary part Xr·Yi + Xi·Yr appears on the same bus with a second strobe. A one-cycle done pulse follows the imaginary result.

The operand port is valid/ready. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. While a product is in progress `in_ready` stays low, so the source must hold its data and wait. The result side has no back-pressure: each strobe lasts exactly one cycle and the consumer must take it then. The last result stays on `res_data` while the block is idle.

Top module: `cplx_seq_mul`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it: `in_ready` is 1; `res_re_valid`, `res_im_valid` and `res_done` are 0; `res_data` is 0.
- R2: After the edge where an operand set is accepted (`in_valid` and `in_ready` both 1), `in_ready` is 0 for the next five cycles. It returns to 1 in the cycle where `res_done` is 1.
- R3: Call the accept edge k. `res_re_valid` is 1 for exactly one cycle, the cycle after edge k+2. In that cycle `res_data` equals Xr·Yr − Xi·Yi.
- R4: `res_im_valid` is 1 for exactly one cycle, the cycle after edge k+4 (two cycles after the real strobe). In that cycle `res_data` equals Xr·Yi + Xi·Yr.
- R5: `res_done` is 1 for exactly one cycle, the one directly after the imaginary strobe. A new operand set offered in that cycle is accepted at its closing edge, so back-to-back products start every six cycles.
- R6: Changes on the operand inputs and `in_valid` while `in_ready` is 0 have no effect on the results of the product in progress.
- R7: Operands are 18-bit two's complement, and all values including −131072 are allowed. Results are exact 48-bit two's complement, sign-extended, with no rounding or saturation.
- R8: While the block is idle (`in_ready` high on the previous edge), `res_data` holds its value.
- R9: At most one of `res_re_valid`, `res_im_valid` and `res_done` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can accept an operand set |
| op_x_re | input | 18 | Real part of X, signed |
| op_x_im | input | 18 | Imaginary part of X, signed |
| op_y_re | input | 18 | Real part of Y, signed |
| op_y_im | input | 18 | Imaginary part of Y, signed |
| res_data | output | 48 | Accumulator value, signed; real or imaginary result when strobed |
| res_re_valid | output | 1 | One-cycle strobe: res_data holds the real part |
| res_im_valid | output | 1 | One-cycle strobe: res_data holds the imaginary part |
| res_done | output | 1 | One-cycle pulse after the imaginary result |

## Verification
A wrong slot selection or a wrong add/subtract choice in one multiply cycle corrupts `res_data`. The error shows on the strobe that closes that half of the product, at most two cycles after the faulty step. A stuck or skipped sequencer state moves a strobe or `in_ready` off its fixed offset from the accept edge, and the bench's cycle model sees this in the very cycle it happens. The operand cases are chosen so that a stored slot loaded from the wrong input shows up in the result: most-negative values, mixed extremes, and operands that change while the block is busy.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RR,   // Xr*Yr, load accumulator
    ST_II,   // minus Xi*Yi
    ST_RI,   // Xr*Yi, load accumulator (real result shown)
    ST_IR,   // plus Xi*Yr
    ST_FIN,  // imaginary result shown
    ST_DONE  // done pulse, ready again
  } cmul_state_e;

  localparam logic SLOT_RE = 1'b0;
  localparam logic SLOT_IM = 1'b1;

  typedef struct packed {
    logic sel_x;
    logic sel_y;
    logic acc_en;
    logic acc_load;
    logic acc_sub;
  } cmul_ctrl_t;

endpackage

// File: rtl/cmul_opbank.sv
module cmul_opbank #(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic signed [W-1:0] d_re,
  input  logic signed [W-1:0] d_im,
  input  logic                sel,
  output logic signed [W-1:0] q
);
  localparam int NSLOT = 2;

  logic signed [W-1:0] din    [NSLOT];
  logic signed [W-1:0] slot_q [NSLOT];

  assign din[0] = d_re;
  assign din[1] = d_im;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[g] <= '0;
      else if (load) slot_q[g] <= din[g];
    end
  end

  assign q = slot_q[sel];
endmodule

// File: rtl/cmul_seq.sv
module cmul_seq
  import cmul_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       ready,
  output logic       take,
  output cmul_ctrl_t ctrl,
  output logic       re_valid,
  output logic       im_valid,
  output logic       done
);
  cmul_state_e state_q, state_d;

  assign ready = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign take  = ready && start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take) state_d = ST_RR;
      ST_RR:   state_d = ST_II;
      ST_II:   state_d = ST_RI;
      ST_RI:   state_d = ST_IR;
      ST_IR:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_DONE;
      ST_DONE: state_d = take ? ST_RR : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    ctrl = '0;
    unique case (state_q)
      ST_RR: ctrl = '{sel_x: SLOT_RE, sel_y: SLOT_RE, acc_en: 1'b1, acc_load: 1'b1, acc_sub: 1'b0};
      ST_II: ctrl = '{sel_x: SLOT_IM, sel_y: SLOT_IM, acc_en: 1'b1, acc_load: 1'b0, acc_sub: 1'b1};
      ST_RI: ctrl = '{sel_x: SLOT_RE, sel_y: SLOT_IM, acc_en: 1'b1, acc_load: 1'b1, acc_sub: 1'b0};
      ST_IR: ctrl = '{sel_x: SLOT_IM, sel_y: SLOT_RE, acc_en: 1'b1, acc_load: 1'b0, acc_sub: 1'b0};
      default: ctrl = '0;
    endcase
  end

  assign re_valid = (state_q == ST_RI);
  assign im_valid = (state_q == ST_FIN);
  assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/cmul_mac.sv
module cmul_mac
  import cmul_pkg::*;
#(
  parameter int W    = 18,
  parameter int ACCW = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [W-1:0]    x,
  input  logic signed [W-1:0]    y,
  input  cmul_ctrl_t             ctrl,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW  = 2 * W;
  localparam int EXT = ACCW - PW;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_ext;

  assign prod     = x * y;
  assign prod_ext = {{EXT{prod[PW-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc <= '0;
    else if (ctrl.acc_en) begin
      if (ctrl.acc_load)     acc <= prod_ext;
      else if (ctrl.acc_sub) acc <= acc - prod_ext;
      else                   acc <= acc + prod_ext;
    end
  end
endmodule

// File: rtl/cplx_seq_mul.sv
module cplx_seq_mul
  import cmul_pkg::*;
#(
  parameter int OPW  = 18,
  parameter int ACCW = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [OPW-1:0]  op_x_re,
  input  logic signed [OPW-1:0]  op_x_im,
  input  logic signed [OPW-1:0]  op_y_re,
  input  logic signed [OPW-1:0]  op_y_im,
  output logic signed [ACCW-1:0] res_data,
  output logic                   res_re_valid,
  output logic                   res_im_valid,
  output logic                   res_done
);
  logic                  take;
  cmul_ctrl_t            ctrl;
  logic signed [OPW-1:0] mul_x, mul_y;

  cmul_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (in_valid),
    .ready    (in_ready),
    .take     (take),
    .ctrl     (ctrl),
    .re_valid (res_re_valid),
    .im_valid (res_im_valid),
    .done     (res_done)
  );

  cmul_opbank #(.W(OPW)) u_bank_x (
    .clk (clk), .rst_n (rst_n), .load (take),
    .d_re (op_x_re), .d_im (op_x_im), .sel (ctrl.sel_x), .q (mul_x)
  );

  cmul_opbank #(.W(OPW)) u_bank_y (
    .clk (clk), .rst_n (rst_n), .load (take),
    .d_re (op_y_re), .d_im (op_y_im), .sel (ctrl.sel_y), .q (mul_y)
  );

  cmul_mac #(.W(OPW), .ACCW(ACCW)) u_mac (
    .clk (clk), .rst_n (rst_n), .x (mul_x), .y (mul_y), .ctrl (ctrl), .acc (res_data)
  );
endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
  parameter int ACCW = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [ACCW-1:0] res_data,
  input logic            res_re_valid,
  input logic            res_im_valid,
  input logic            res_done
);
  // R2: busy after an accepted transfer
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R3: real strobe at fixed offset from the accept edge
  a_r3_real_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##3 res_re_valid);

  a_r3_real_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_re_valid |=> !res_re_valid);

  // R4: imaginary strobe two cycles after the real one
  a_r4_imag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_re_valid |-> ##2 res_im_valid);

  // R5: done right after imaginary, with ready
  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_im_valid |=> res_done);

  a_r5_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> in_ready);

  // R8: idle holds the result
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> $stable(res_data));

  // R9: strobes are mutually exclusive
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_re_valid, res_im_valid, res_done}));
endmodule

bind cplx_seq_mul cmul_checker #(.ACCW(ACCW)) u_cmul_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .res_data     (res_data),
  .res_re_valid (res_re_valid),
  .res_im_valid (res_im_valid),
  .res_done     (res_done)
);

// File: tb/test_cplx_seq_mul.sv
module test_cplx_seq_mul;
  localparam int W  = 18;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [W-1:0]  xr = '0, xi = '0, yr = '0, yi = '0;
  logic signed [AW-1:0] res_data;
  logic                 res_re_valid, res_im_valid, res_done;

  cplx_seq_mul #(.OPW(W), .ACCW(AW)) i_cplx_seq_mul (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .op_x_re (xr), .op_x_im (xi), .op_y_re (yr), .op_y_im (yi),
    .res_data (res_data), .res_re_valid (res_re_valid),
    .res_im_valid (res_im_valid), .res_done (res_done)
  );

  int     n_vec = 0, n_bad = 0, cyc = 0;
  int     cnt = 0;          // edges since accept, 0 = idle
  logic   m_took = 1'b0;
  longint e_re = 0, e_im = 0, e_hold = 0;
  string  case_tag = "R3", op_tag = "R3";

  task automatic chk(string tag, longint act, longint exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model: one step per clock edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      cnt = 0; m_took = 1'b0; e_hold = 0;
    end else begin
      m_took = 1'b0;
      if (in_valid && (cnt == 0 || cnt == 6)) begin
        e_re = longint'(xr) * longint'(yr) - longint'(xi) * longint'(yi);
        e_im = longint'(xr) * longint'(yi) + longint'(xi) * longint'(yr);
        op_tag = case_tag;
        cnt = 1; m_took = 1'b1;
      end else if (cnt == 6) cnt = 0;
      else if (cnt != 0) cnt++;
      if (cnt == 5) e_hold = e_im;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 ready in reset", longint'(in_ready), 1);
      chk("R1 strobes in reset", longint'({res_re_valid, res_im_valid, res_done}), 0);
      chk("R1 data in reset", longint'(res_data), 0);
    end else begin
      chk("R2 in_ready", longint'(in_ready), longint'(cnt == 0 || cnt == 6));
      chk("R3 res_re_valid", longint'(res_re_valid), longint'(cnt == 3));
      chk("R4 res_im_valid", longint'(res_im_valid), longint'(cnt == 5));
      chk("R5 res_done", longint'(res_done), longint'(cnt == 6));
      if (cnt == 3) chk({"R3 real part ", op_tag}, longint'(res_data), e_re);
      if (cnt == 5) chk({"R4 imag part ", op_tag}, longint'(res_data), e_im);
      if (cnt == 0 || cnt == 6) chk("R8 idle hold", longint'(res_data), e_hold);
    end
  end

  // driver: offer an operand set, wait for acceptance, optionally disturb inputs
  task automatic run_op(input logic signed [W-1:0] a_r, a_i, b_r, b_i,
                        input string tag, input bit disturb, input int gap);
    xr = a_r; xi = a_i; yr = b_r; yi = b_i; case_tag = tag; in_valid = 1'b1;
    do @(negedge clk); while (!m_took);
    if (disturb) begin
      // R6: new values and valid while busy must not reach the product
      xr = ~a_r; xi = a_r ^ b_i; yr = -b_r; yi = b_i + 18'sd77;
      repeat (3) @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  localparam logic signed [W-1:0] MINV = -18'sd131072;
  localparam logic signed [W-1:0] MAXV =  18'sd131071;

  int unsigned rs = 32'h1234_5678;
  function automatic int unsigned nxt(int unsigned s);
    int unsigned t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op(18'sd0, 18'sd0, 18'sd0, 18'sd0, "R3", 1'b0, 2);
    run_op(18'sd1, 18'sd2, 18'sd3, 18'sd4, "R3", 1'b0, 1);
    run_op(-18'sd7, 18'sd5, 18'sd9, -18'sd11, "R6", 1'b1, 0);
    run_op(MINV, MINV, MINV, MINV, "R7", 1'b0, 0);
    run_op(MAXV, MAXV, MAXV, MAXV, "R7", 1'b1, 0);
    run_op(MINV, MAXV, MAXV, MINV, "R7", 1'b0, 0);
    run_op(MAXV, MINV, MINV, MAXV, "R7", 1'b0, 3);
    run_op(MINV, 18'sd0, MINV, 18'sd0, "R7", 1'b1, 0);
    for (int k = 0; k < 40; k++) begin
      logic signed [W-1:0] r0, r1, r2, r3;
      rs = nxt(rs); r0 = rs[W-1:0];
      rs = nxt(rs); r1 = rs[W-1:0];
      rs = nxt(rs); r2 = rs[W-1:0];
      rs = nxt(rs); r3 = rs[W-1:0];
      run_op(r0, r1, r2, r3, (k % 2 == 0) ? "R6" : "R5", k % 2 == 0, k % 5);
    end
    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule